// File: doc/BRIEF.md
# Memory Region Security Filter

This block is placed in front of one large memory and splits the memory's address range into security regions. It has a fixed background region and a set of programmable regions. Each programmable region has an enable, an inclusive base, an inclusive limit and a security attribute. Every access on the access port carries a three-bit protection field. Bit 1 of that field says whether the access is Secure (0) or Non-secure (1). The filter looks up the region that owns the address and compares the access's security bit with that region's attribute. It then either forwards the access or blocks it with an error.

A blocked access is recorded in a sticky fault record: the failing address and its security bit. The record keeps the first fault until Secure software clears it. Region settings and the fault record are reached through a separate programming port, and that port serves Secure accesses only. All responses on both ports are registered and appear one cycle after the request is sampled.

Top module: `region_sec_filter`

## Requirements
- R1: An access sampled with `acc_valid` high gives exactly one response in the next cycle. The response is either `fwd_valid` carrying the same address and protection field, or `acc_err`. It is never both. An idle cycle gives no response.
- R2: Region 0 is a background region covering every address. Its attribute resets to Secure and can be changed through its control word. Its control word reads with the enable bit at 1. Its base reads as 0 and its limit reads as all ones, and writes to its base and limit are ignored.
- R3: Programmable regions 1 to 8 reset disabled, with attribute Secure, base 0 and limit 0. An enabled region owns every address from its base to its limit, including both ends.
- R4: Where enabled regions overlap, the highest-numbered one decides the attribute. Region 0 applies only where no enabled programmable region matches.
- R5: Bit 1 of the protection field is 0 for a Secure access and 1 for a Non-secure access. A Secure access passes to any region. A Non-secure access passes only to a region whose attribute is Non-secure, and is blocked otherwise.
- R6: A blocked access sets the fault record. The status word at index 36 holds bit 0 = valid and bit 1 = the blocked access's protection bit 1. The address word at index 37 holds the blocked address. While the record is valid, later faults do not overwrite it.
- R7: A Secure write of any data to index 36 clears the fault record. If a blocked access arrives in the same cycle, the record is left valid and holds the new fault.
- R8: A Secure read on the programming port returns the addressed word with `cfg_rvalid` one cycle later. A Secure write is used by accesses sampled in the following cycle and later.
- R9: A programming-port access whose protection bit 1 is 1 gets `cfg_err` one cycle later, with no `cfg_rvalid` and `cfg_rdata` 0. It changes no register.
- R10: The word index is 4*r + f for region r. Field f is 0 for control, 1 for base and 2 for limit. In the control word, bit 0 is enable and bit 1 is the attribute (1 = Secure, 0 = Non-secure). Unmapped indices read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | ADDR_W | Access address |
| acc_prot | input | 3 | Access protection field, bit 1 = Non-secure |
| fwd_valid | output | 1 | Access forwarded to memory |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_prot | output | 3 | Forwarded protection field |
| acc_err | output | 1 | Access blocked, error response |
| cfg_valid | input | 1 | Programming request present |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_prot | input | 3 | Programming protection field, bit 1 = Non-secure |
| cfg_idx | input | CFG_IDX_W | Register word index |
| cfg_wdata | input | ADDR_W | Write data |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | ADDR_W | Read data |
| cfg_err | output | 1 | Programming request refused |

## Verification
The address patterns are chosen so that each one isolates a single rule. Accesses land exactly on a region's base and limit, and one address past each, to show the bounds are inclusive. Addresses inside a three-deep overlap show that the highest-numbered region wins. Addresses that fall only into the background show the fallback. Each address is sent as both Secure and Non-secure, which separates the attribute check from the region match. Further cases cover a Non-secure programming write followed by an access that would reveal any change it made, a retyping of the background region, and a fault clear in the same cycle as a new fault.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

    typedef enum logic [1:0] {
        FLD_CTRL  = 2'd0,
        FLD_BASE  = 2'd1,
        FLD_LIMIT = 2'd2,
        FLD_NONE  = 2'd3
    } fld_e;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_PASS  = 2'd1,
        RSP_BLOCK = 2'd2
    } rsp_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SEC_BIT = 1;

    function automatic logic prot_ns(input logic [2:0] p);
        return p[1];
    endfunction

    function automatic int flt_stat_index(input int nreg);
        return 4 * nreg;
    endfunction

    function automatic int flt_addr_index(input int nreg);
        return 4 * nreg + 1;
    endfunction

endpackage

// File: rtl/rsf_match.sv
module rsf_match #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 9
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [NREG-1:0]              en,
    input  logic [NREG-1:0]              sec,
    input  logic [NREG-1:0][ADDR_W-1:0]  base,
    input  logic [NREG-1:0][ADDR_W-1:0]  limit,
    output logic                         hit_sec
);
    logic [NREG-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_hit
            assign hit[g] = en[g] && (addr >= base[g]) && (addr <= limit[g]);
        end
    endgenerate

    always_comb begin
        hit_sec = sec[0];
        for (int i = 1; i < NREG; i++) begin
            if (hit[i]) hit_sec = sec[i];
        end
    end
endmodule

// File: rtl/rsf_gate.sv
module rsf_gate
    import rsf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_prot,
    input  logic              hit_sec,
    output logic              flt_set,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [2:0]        fwd_prot,
    output logic              acc_err
);
    rsp_e rsp_d, rsp_q;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        prot_q;

    always_comb begin
        rsp_d = RSP_IDLE;
        if (acc_valid) begin
            if (prot_ns(acc_prot) && hit_sec) rsp_d = RSP_BLOCK;
            else                              rsp_d = RSP_PASS;
        end
    end

    assign flt_set = (rsp_d == RSP_BLOCK);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q  <= RSP_IDLE;
            addr_q <= '0;
            prot_q <= '0;
        end else begin
            rsp_q <= rsp_d;
            if (acc_valid) begin
                addr_q <= acc_addr;
                prot_q <= acc_prot;
            end
        end
    end

    assign fwd_valid = (rsp_q == RSP_PASS);
    assign acc_err   = (rsp_q == RSP_BLOCK);
    assign fwd_addr  = fwd_valid ? addr_q : '0;
    assign fwd_prot  = fwd_valid ? prot_q : '0;

    AST_ONE_RESP: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fwd_valid, acc_err})); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !fwd_valid && !acc_err); // R1
    AST_NS_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_prot[1] && hit_sec |=> acc_err && !fwd_valid); // R5
    AST_S_PASSES: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_prot[1] |=> fwd_valid && fwd_addr == $past(acc_addr)); // R5
endmodule

// File: rtl/rsf_regfile.sv
module rsf_regfile
    import rsf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NREG      = 9,
    parameter int CFG_IDX_W = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_valid,
    input  logic                         cfg_write,
    input  logic                         cfg_ns,
    input  logic [CFG_IDX_W-1:0]         cfg_idx,
    input  logic [ADDR_W-1:0]            cfg_wdata,
    output logic                         cfg_rvalid,
    output logic [ADDR_W-1:0]            cfg_rdata,
    output logic                         cfg_err,
    input  logic                         flt_set,
    input  logic [ADDR_W-1:0]            flt_addr,
    input  logic                         flt_ns,
    output logic [NREG-1:0]              en_q,
    output logic [NREG-1:0]              sec_q,
    output logic [NREG-1:0][ADDR_W-1:0]  base_q,
    output logic [NREG-1:0][ADDR_W-1:0]  limit_q
);
    localparam int SEL_W = CFG_IDX_W - 2;
    localparam logic [CFG_IDX_W-1:0] STAT_IDX = CFG_IDX_W'(flt_stat_index(NREG));
    localparam logic [CFG_IDX_W-1:0] FADR_IDX = CFG_IDX_W'(flt_addr_index(NREG));

    logic [SEL_W-1:0]  sel;
    fld_e              fld;
    logic              acc_ok, wr, clr;
    logic              fv_q, fns_q;
    logic [ADDR_W-1:0] fadr_q;
    logic [ADDR_W-1:0] rd;

    assign sel    = cfg_idx[CFG_IDX_W-1:2];
    assign fld    = fld_e'(cfg_idx[1:0]);
    assign acc_ok = cfg_valid && !cfg_ns;
    assign wr     = acc_ok && cfg_write;
    assign clr    = wr && (cfg_idx == STAT_IDX);

    // Background region: fixed span, retypable attribute
    assign en_q[0]    = 1'b1;
    assign base_q[0]  = '0;
    assign limit_q[0] = '1;

    always_ff @(posedge clk) begin
        if (rst)                                          sec_q[0] <= 1'b1;
        else if (wr && sel == '0 && fld == FLD_CTRL)      sec_q[0] <= cfg_wdata[CTRL_SEC_BIT];
    end

    genvar g;
    generate
        for (g = 1; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    en_q[g]    <= 1'b0;
                    sec_q[g]   <= 1'b1;
                    base_q[g]  <= '0;
                    limit_q[g] <= '0;
                end else if (wr && int'(sel) == g) begin
                    case (fld)
                        FLD_CTRL: begin
                            en_q[g]  <= cfg_wdata[CTRL_EN_BIT];
                            sec_q[g] <= cfg_wdata[CTRL_SEC_BIT];
                        end
                        FLD_BASE:  base_q[g]  <= cfg_wdata;
                        FLD_LIMIT: limit_q[g] <= cfg_wdata;
                        default: ;
                    endcase
                end
            end
        end
    endgenerate

    // Sticky fault record; a new fault wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            fv_q   <= 1'b0;
            fns_q  <= 1'b0;
            fadr_q <= '0;
        end else if (flt_set && (!fv_q || clr)) begin
            fv_q   <= 1'b1;
            fns_q  <= flt_ns;
            fadr_q <= flt_addr;
        end else if (clr) begin
            fv_q   <= 1'b0;
            fns_q  <= 1'b0;
            fadr_q <= '0;
        end
    end

    always_comb begin
        rd = '0;
        if (int'(sel) < NREG) begin
            case (fld)
                FLD_CTRL: begin
                    rd[CTRL_EN_BIT]  = en_q[sel];
                    rd[CTRL_SEC_BIT] = sec_q[sel];
                end
                FLD_BASE:  rd = base_q[sel];
                FLD_LIMIT: rd = limit_q[sel];
                default:   rd = '0;
            endcase
        end else if (cfg_idx == STAT_IDX) begin
            rd[0] = fv_q;
            rd[1] = fns_q;
        end else if (cfg_idx == FADR_IDX) begin
            rd = fadr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
            cfg_err    <= 1'b0;
        end else begin
            cfg_rvalid <= acc_ok && !cfg_write;
            cfg_rdata  <= (acc_ok && !cfg_write) ? rd : '0;
            cfg_err    <= cfg_valid && cfg_ns;
        end
    end

    AST_NS_CFG_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        cfg_valid && cfg_ns |=> $stable(en_q) && $stable(sec_q)
                                && $stable(base_q) && $stable(limit_q)); // R9
    AST_FLT_STICKY: assert property (@(posedge clk) disable iff (rst)
        fv_q && !clr |=> fv_q && $stable(fadr_q) && $stable(fns_q)); // R6
    AST_FLT_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        flt_set |=> fv_q); // R7
endmodule

// File: rtl/region_sec_filter.sv
module region_sec_filter
    import rsf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_PROG  = 8,
    parameter int NREG      = NUM_PROG + 1,
    parameter int CFG_IDX_W = $clog2(4 * NREG + 2)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_valid,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [2:0]            acc_prot,
    output logic                  fwd_valid,
    output logic [ADDR_W-1:0]     fwd_addr,
    output logic [2:0]            fwd_prot,
    output logic                  acc_err,
    input  logic                  cfg_valid,
    input  logic                  cfg_write,
    input  logic [2:0]            cfg_prot,
    input  logic [CFG_IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0]     cfg_wdata,
    output logic                  cfg_rvalid,
    output logic [ADDR_W-1:0]     cfg_rdata,
    output logic                  cfg_err
);
    logic [NREG-1:0]             en_q, sec_q;
    logic [NREG-1:0][ADDR_W-1:0] base_q, limit_q;
    logic                        hit_sec, flt_set;

    rsf_regfile #(.ADDR_W(ADDR_W), .NREG(NREG), .CFG_IDX_W(CFG_IDX_W)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_ns(prot_ns(cfg_prot)),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .flt_set(flt_set), .flt_addr(acc_addr), .flt_ns(prot_ns(acc_prot)),
        .en_q(en_q), .sec_q(sec_q), .base_q(base_q), .limit_q(limit_q)
    );

    rsf_match #(.ADDR_W(ADDR_W), .NREG(NREG)) u_match (
        .addr(acc_addr), .en(en_q), .sec(sec_q),
        .base(base_q), .limit(limit_q), .hit_sec(hit_sec)
    );

    rsf_gate #(.ADDR_W(ADDR_W)) u_gate (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_prot(acc_prot),
        .hit_sec(hit_sec), .flt_set(flt_set),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_prot(fwd_prot),
        .acc_err(acc_err)
    );
endmodule

// File: tb/tb_region_sec_filter.sv
`timescale 1ns/1ps
module tb_region_sec_filter;
    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [2:0]  acc_prot = '0;
    logic        fwd_valid, acc_err;
    logic [31:0] fwd_addr;
    logic [2:0]  fwd_prot;
    logic        cfg_valid = 1'b0, cfg_write = 1'b0;
    logic [2:0]  cfg_prot = '0;
    logic [5:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid, cfg_err;
    logic [31:0] cfg_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    region_sec_filter dut (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_prot(acc_prot),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_prot(fwd_prot), .acc_err(acc_err),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_prot(cfg_prot),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        ns;
        logic        err;
    } vec_t;

    // Region 1 [1000,1FFF] NS; region 2 [1800,18FF] S; region 8 [1880,188F] NS; region 0 S
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0100, 1'b0, 1'b0},
        '{32'h0000_0100, 1'b1, 1'b1},
        '{32'h0000_1000, 1'b1, 1'b0},
        '{32'h0000_1FFF, 1'b1, 1'b0},
        '{32'h0000_2000, 1'b1, 1'b1},
        '{32'h0000_0FFF, 1'b1, 1'b1},
        '{32'h0000_1800, 1'b1, 1'b1},
        '{32'h0000_1880, 1'b1, 1'b0},
        '{32'h0000_188F, 1'b1, 1'b0},
        '{32'h0000_1890, 1'b1, 1'b1},
        '{32'h0000_1850, 1'b0, 1'b0},
        '{32'hFFFF_FFFF, 1'b1, 1'b1},
        '{32'hFFFF_FFFF, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, input logic ns, input logic exp_err,
                          input string req);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_prot = {1'b0, ns, 1'b0};
        @(negedge clk);
        acc_valid = 1'b0;
        check(req, {30'd0, fwd_valid, acc_err}, {30'd0, !exp_err, exp_err});
        if (!exp_err) begin
            check(req, fwd_addr, a);
            check(req, {29'd0, fwd_prot}, {29'd0, 1'b0, ns, 1'b0});
        end
    endtask

    task automatic cfg(input logic wr, input logic ns, input int idx, input logic [31:0] wd,
                       output logic [31:0] rd, output logic rv, output logic er);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = wr; cfg_prot = {1'b0, ns, 1'b0};
        cfg_idx = 6'(idx); cfg_wdata = wd;
        @(negedge clk);
        cfg_valid = 1'b0;
        rd = cfg_rdata; rv = cfg_rvalid; er = cfg_err;
    endtask

    task automatic sread(input int idx, input logic [31:0] exp, input string req);
        logic [31:0] rd; logic rv, er;
        cfg(1'b0, 1'b0, idx, '0, rd, rv, er);
        check(req, {30'd0, rv, er}, 32'd2);
        check(req, rd, exp);
    endtask

    task automatic swrite(input int idx, input logic [31:0] wd);
        logic [31:0] rd; logic rv, er;
        cfg(1'b1, 1'b0, idx, wd, rd, rv, er);
    endtask

    always @(posedge clk) begin
        if (!done && total >= 0 && $time > 100000 * 5) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd; logic rv, er;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // Reset state
        check("R1 reset", {30'd0, fwd_valid, acc_err}, 32'd0);
        check("R9 reset", {30'd0, cfg_rvalid, cfg_err}, 32'd0);
        sread(0, 32'h3, "R2 reset ctrl0");
        sread(1, 32'h0, "R2 base0");
        sread(2, 32'hFFFF_FFFF, "R2 limit0");
        sread(4, 32'h2, "R3 reset ctrl1");
        sread(6, 32'h0, "R3 reset limit1");
        sread(36, 32'h0, "R6 reset status");
        sread(40, 32'h0, "R10 unmapped");
        check("R1 idle", {30'd0, fwd_valid, acc_err}, 32'd0);

        // Program regions (R10 map)
        swrite(5, 32'h1000);  swrite(6, 32'h1FFF);  swrite(4, 32'h1);
        swrite(9, 32'h1800);  swrite(10, 32'h18FF); swrite(8, 32'h3);
        swrite(33, 32'h1880); swrite(34, 32'h188F); swrite(32, 32'h1);
        sread(9, 32'h1800, "R8 readback base2");
        sread(8, 32'h3, "R10 ctrl2");

        // Vector walk: R3 bounds, R4 priority, R5 attribute check
        for (int i = 0; i < NV; i++)
            access(VECS[i].addr, VECS[i].ns, VECS[i].err, $sformatf("R5 vec%0d", i));

        // R6 sticky first fault
        sread(36, 32'h3, "R6 status");
        sread(37, 32'h0000_0100, "R6 fault addr");
        // R7 clear
        swrite(36, 32'h0);
        sread(36, 32'h0, "R7 cleared");

        // R9 Non-secure programming write has no effect
        cfg(1'b1, 1'b1, 4, 32'h0, rd, rv, er);
        check("R9 ns write err", {30'd0, rv, er}, 32'd1);
        access(32'h1000, 1'b1, 1'b0, "R9 region1 still open");
        cfg(1'b0, 1'b1, 5, 32'h0, rd, rv, er);
        check("R9 ns read err", {30'd0, rv, er}, 32'd1);
        check("R9 ns read data", rd, 32'h0);

        // R2 retype background, writes to its span ignored
        swrite(0, 32'h0);
        access(32'h0000_0100, 1'b1, 1'b0, "R2 background now NS");
        swrite(1, 32'h5);
        sread(1, 32'h0, "R2 base0 ignored");
        sread(0, 32'h1, "R2 ctrl0 retyped");
        swrite(0, 32'h2);
        // R8 write used from next access
        swrite(8, 32'h0);
        access(32'h1800, 1'b1, 1'b0, "R8 region2 disabled");

        // R7 same-cycle clear and new fault: new fault kept
        access(32'h0000_2000, 1'b1, 1'b1, "R6 fault A");
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'hFFFF_FFF0; acc_prot = 3'b010;
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_prot = 3'b000; cfg_idx = 6'd36; cfg_wdata = '0;
        @(negedge clk);
        acc_valid = 1'b0; cfg_valid = 1'b0;
        check("R7 blocked", {31'd0, acc_err}, 32'd1);
        sread(36, 32'h3, "R7 set wins status");
        sread(37, 32'hFFFF_FFF0, "R7 set wins addr");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule